// File: doc/BRIEF.md
# Configuration Phase Sequencer

This controller walks a reprogrammable logic device through its four life phases: initialization, configuration, start-up and operating. It leaves power-on reset in initialization, waits out a settling delay, then releases an open-drain init line that other devices on the board may still be holding low. The sampled init line must read high twice in a row before the mode select bits are latched and configuration begins. A strobe from the bitstream loader ends configuration. A short start-up phase follows, and during it done rises and the user flip-flop reset is lifted one cycle later.

While loading, the reset pin or the program pin aborts to initialization. After loading, only the program pin forces a new configuration. A watchdog on the configuration phase flags a missing completion strobe and restarts the sequence. User I/O output enable stays off until the device is operating and the global tri-state request is low.

Top module: `cfg_seq_top`

## Requirements
- R1: `io_oe_o` is 0 whenever the phase is initialization or configuration.
- R2: During `rst_ni` low the outputs are: phase 00, `init_rel_o`=0, `done_o`=0, `hdc_o`=1, `ldc_no`=0, `user_rst_o`=1, `io_oe_o`=0, `cfg_err_o`=0, `mode_o`=000.
- R3: On entering initialization `init_rel_o` is 0. It rises on the INIT_DLY-th clock edge spent in initialization. While `init_line_i` stays low the phase stays initialization.
- R4: After `init_rel_o` is high, with both pins high, `init_line_i` must be sampled high on two consecutive edges. At the second edge the phase becomes configuration and `mode_i` is latched into `mode_o`, which then holds while `mode_i` changes.
- R5: `hdc_o`=1 and `ldc_no`=0 in initialization and configuration. `hdc_o`=0 and `ldc_no`=1 in start-up and operating.
- R6: A `cfg_done_i` pulse sampled in configuration moves the phase to start-up and raises `done_o` at that edge. Operating (11) follows SU_CYC (default 3) edges later.
- R7: `user_rst_o` is still 1 in the first cycle `done_o` is high and is 0 from the next cycle on.
- R8: In configuration, `reset_pin_ni` or `prog_ni` low moves the phase to initialization on the next edge. Configuration is not re-entered while either pin is low.
- R9: In start-up and operating, `reset_pin_ni` has no effect. `prog_ni` low moves the phase to initialization, with `done_o`=0 and `user_rst_o`=1.
- R10: In operating, `io_oe_o` equals the inverse of `gts_i`.
- R11: If no `cfg_done_i` arrives within TMO_CYC edges of configuration, the phase returns to initialization and `cfg_err_o` becomes 1. It clears on the next accepted `cfg_done_i`.
- R12: `phase_o` encodes 00 initialization, 01 configuration, 10 start-up, 11 operating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | internal clock |
| rst_ni | input | 1 | power-on reset, asynchronous, active low |
| reset_pin_ni | input | 1 | reset pin, active low |
| prog_ni | input | 1 | program pin, active low |
| init_line_i | input | 1 | sampled state of the wired-AND init line |
| mode_i | input | 3 | configuration mode select |
| cfg_done_i | input | 1 | configuration-complete strobe from loader |
| gts_i | input | 1 | global tri-state request, high keeps I/O off |
| init_rel_o | output | 1 | init line release (1 = let float high) |
| done_o | output | 1 | configuration done |
| hdc_o | output | 1 | high during configuration |
| ldc_no | output | 1 | low during configuration |
| user_rst_o | output | 1 | reset to user flip-flops, active high |
| io_oe_o | output | 1 | user I/O output enable |
| mode_o | output | 3 | latched mode select |
| cfg_err_o | output | 1 | configuration timeout flag |
| phase_o | output | 2 | current phase code |

## Verification
The assertions assume that `cfg_done_i` is a single-cycle strobe and that the pins and `init_line_i` are already synchronous to `clk_i`. The two-cycle qualification check also needs at least two cycles of input history before the first exit from initialization, which the settling delay always provides. The stimulus changes every input just after a falling edge, pulses the completion strobe for exactly one cycle, and drops the init line for one cycle in the middle of a qualification run so the restart of the count is seen.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PH_INIT = 2'b00,
    PH_CFG  = 2'b01,
    PH_STUP = 2'b10,
    PH_OPER = 2'b11
  } phase_e;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int LIMIT = 4,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/init_qual.sv
module init_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic line_i,
  output logic go_o
);
  logic seen_q;

  assign go_o = arm_i && line_i && seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= arm_i && line_i;
  end

  // R4
  go_needs_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> ($past(line_i) && $past(arm_i) && line_i));
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int INIT_DLY = 4,
  parameter int TMO_CYC  = 64,
  parameter int SU_CYC   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_pin_ni,
  input  logic       prog_ni,
  input  logic       init_line_i,
  input  logic [2:0] mode_i,
  input  logic       cfg_done_i,
  input  logic       gts_i,
  output logic       init_rel_o,
  output logic       done_o,
  output logic       hdc_o,
  output logic       ldc_no,
  output logic       user_rst_o,
  output logic       io_oe_o,
  output logic [2:0] mode_o,
  output logic       cfg_err_o,
  output logic [1:0] phase_o
);
  phase_e     phase_q, phase_d;
  logic       init_rel_q, urst_q, err_q;
  logic [2:0] mode_q;
  logic       idly_hit, tmo_hit, su_hit, qual_go, qual_arm, abort;

  assign abort    = !reset_pin_ni || !prog_ni;
  assign qual_arm = (phase_q == PH_INIT) && init_rel_q && reset_pin_ni && prog_ni;

  phase_timer #(.LIMIT(INIT_DLY)) u_idly (
    .clk_i, .rst_ni,
    .clr_i(phase_q != PH_INIT),
    .en_i (!init_rel_q),
    .hit_o(idly_hit)
  );

  phase_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk_i, .rst_ni,
    .clr_i(phase_q != PH_CFG),
    .en_i (1'b1),
    .hit_o(tmo_hit)
  );

  phase_timer #(.LIMIT(SU_CYC)) u_su (
    .clk_i, .rst_ni,
    .clr_i(phase_q != PH_STUP),
    .en_i (1'b1),
    .hit_o(su_hit)
  );

  init_qual u_qual (
    .clk_i, .rst_ni,
    .arm_i (qual_arm),
    .line_i(init_line_i),
    .go_o  (qual_go)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_INIT: if (qual_go) phase_d = PH_CFG;
      PH_CFG: begin
        if (abort)           phase_d = PH_INIT;
        else if (cfg_done_i) phase_d = PH_STUP;
        else if (tmo_hit)    phase_d = PH_INIT;
      end
      PH_STUP: begin
        if (!prog_ni)    phase_d = PH_INIT;
        else if (su_hit) phase_d = PH_OPER;
      end
      PH_OPER: if (!prog_ni) phase_d = PH_INIT;
      default: phase_d = PH_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_INIT;
      init_rel_q <= 1'b0;
      urst_q     <= 1'b1;
      err_q      <= 1'b0;
      mode_q     <= '0;
    end else begin
      phase_q    <= phase_d;
      init_rel_q <= (phase_d == PH_INIT) &&
                    (init_rel_q || ((phase_q == PH_INIT) && idly_hit));
      // lift user reset only after a full cycle with done high
      urst_q     <= !(phase_q[1] && phase_d[1]);
      if (phase_q == PH_CFG && phase_d == PH_STUP)
        err_q <= 1'b0;
      else if (phase_q == PH_CFG && !abort && !cfg_done_i && tmo_hit)
        err_q <= 1'b1;
      if (phase_q == PH_INIT && phase_d == PH_CFG)
        mode_q <= mode_i;
    end
  end

  assign init_rel_o = init_rel_q;
  assign done_o     = phase_q[1];
  assign hdc_o      = !phase_q[1];
  assign ldc_no     = phase_q[1];
  assign user_rst_o = urst_q;
  assign io_oe_o    = (phase_q == PH_OPER) && !gts_i;
  assign mode_o     = mode_q;
  assign cfg_err_o  = err_q;
  assign phase_o    = phase_q;

  // R1
  io_off_loading_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o inside {2'b00, 2'b01}) |-> !io_oe_o);

  // R7
  urst_held_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> user_rst_o);

  // R7
  urst_lift_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && prog_ni) |=> !user_rst_o);

  // R8
  cfg_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CFG && abort) |=> phase_q == PH_INIT);

  // R8
  no_cfg_while_pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INIT && abort) |=> phase_q == PH_INIT);

  // R9
  reset_pin_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_OPER && prog_ni) |=> phase_q == PH_OPER);

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_INIT) |=> $stable(mode_o));

  // R6
  startup_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STUP && $past(phase_q) == PH_STUP && $past(phase_q, 2) == PH_STUP)
      |=> phase_q != PH_STUP);
endmodule

// File: tb/cfg_seq_top_test.sv
`timescale 1ns/100ps
module cfg_seq_top_test;
  localparam int IDLY = 4;
  localparam int TMO  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reset_pin_ni = 1'b1, prog_ni = 1'b1, init_line_i = 1'b0;
  logic [2:0] mode_i = 3'b101;
  logic cfg_done_i = 1'b0, gts_i = 1'b1;
  logic init_rel_o, done_o, hdc_o, ldc_no, user_rst_o, io_oe_o, cfg_err_o;
  logic [2:0] mode_o;
  logic [1:0] phase_o;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  cfg_seq_top #(.INIT_DLY(IDLY), .TMO_CYC(TMO), .SU_CYC(3)) uut (
    .clk_i(clk), .rst_ni, .reset_pin_ni, .prog_ni, .init_line_i, .mode_i,
    .cfg_done_i, .gts_i, .init_rel_o, .done_o, .hdc_o, .ldc_no, .user_rst_o,
    .io_oe_o, .mode_o, .cfg_err_o, .phase_o
  );

  // expected vector: {phase, init_rel, done, hdc, ldc_n, urst, oe, err, mode}
  logic [12:0] exp_q[$];
  string       tag_q[$];

  task automatic push(string req, logic [1:0] ph, logic irel, logic urst,
                      logic err, logic [2:0] md);
    exp_q.push_back({ph, irel, ph[1], ~ph[1], ph[1], urst,
                     (ph == 2'b11) & ~gts_i, err, md});
    tag_q.push_back(req);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations half a step after the falling edge
  initial forever begin
    @(negedge clk);
    #0.5;
    while (exp_q.size() > 0) begin
      logic [12:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {phase_o, init_rel_o, done_o, hdc_o, ldc_no, user_rst_o, io_oe_o,
           cfg_err_o, mode_o};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=%b expected=%b (ph irel done hdc ldcn urst oe err mode)",
                 t, a, e);
      end
    end
  end

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    push("R2/R5/R12 reset", 2'b00, 0, 1, 0, 3'b000);
    #1 rst_ni = 1'b1;
    cyc(IDLY - 1);
    push("R3 init held", 2'b00, 0, 1, 0, 3'b000);
    cyc(1);
    push("R3 init released", 2'b00, 1, 1, 0, 3'b000);
    cyc(5);
    push("R3 line low blocks", 2'b00, 1, 1, 0, 3'b000);
    #1 init_line_i = 1'b1;
    cyc(1);
    push("R4 one high not enough", 2'b00, 1, 1, 0, 3'b000);
    #1 init_line_i = 1'b0;
    cyc(1);
    #1 init_line_i = 1'b1;
    cyc(1);
    push("R4 count restarted", 2'b00, 1, 1, 0, 3'b000);
    cyc(1);
    push("R4/R1/R5 enter config", 2'b01, 0, 1, 0, 3'b101);
    #1 mode_i = 3'b010;
    cyc(1);
    push("R4 mode held", 2'b01, 0, 1, 0, 3'b101);
    #1 reset_pin_ni = 1'b0;
    cyc(1);
    push("R8 reset pin abort", 2'b00, 0, 1, 0, 3'b101);
    cyc(8);
    push("R8 blocked while pin low", 2'b00, 1, 1, 0, 3'b101);
    #1 reset_pin_ni = 1'b1;
    cyc(1);
    push("R8 first qualify", 2'b00, 1, 1, 0, 3'b101);
    cyc(1);
    push("R4 re-enter config", 2'b01, 0, 1, 0, 3'b010);
    cyc(TMO - 1);
    push("R11 before timeout", 2'b01, 0, 1, 0, 3'b010);
    cyc(1);
    push("R11 timeout", 2'b00, 0, 1, 1, 3'b010);
    cyc(IDLY + 2);
    push("R11 err kept", 2'b01, 0, 1, 1, 3'b010);
    #1 cfg_done_i = 1'b1;
    cyc(1);
    push("R6/R7/R11/R5 startup", 2'b10, 0, 1, 0, 3'b010);
    #1 begin cfg_done_i = 1'b0; reset_pin_ni = 1'b0; end
    cyc(1);
    push("R7/R9 urst lifted", 2'b10, 0, 0, 0, 3'b010);
    cyc(1);
    push("R6 still startup", 2'b10, 0, 0, 0, 3'b010);
    cyc(1);
    push("R6/R10 operating gts high", 2'b11, 0, 0, 0, 3'b010);
    cyc(2);
    push("R9 reset pin ignored", 2'b11, 0, 0, 0, 3'b010);
    #1 gts_i = 1'b0;
    cyc(1);
    push("R10 io enabled", 2'b11, 0, 0, 0, 3'b010);
    #1 gts_i = 1'b1;
    cyc(1);
    push("R10 io off again", 2'b11, 0, 0, 0, 3'b010);
    #1 begin gts_i = 1'b0; prog_ni = 1'b0; end
    cyc(1);
    push("R9/R1 program from operating", 2'b00, 0, 1, 0, 3'b010);
    #1 begin prog_ni = 1'b1; reset_pin_ni = 1'b1; mode_i = 3'b110; end
    cyc(IDLY + 2);
    push("R4 config after program", 2'b01, 0, 1, 0, 3'b110);
    #1 prog_ni = 1'b0;
    cyc(1);
    push("R8 program abort", 2'b00, 0, 1, 0, 3'b110);
    #1 prog_ni = 1'b1;
    cyc(IDLY + 2);
    push("R4 config again", 2'b01, 0, 1, 0, 3'b110);
    #1 cfg_done_i = 1'b1;
    cyc(1);
    push("R6 startup again", 2'b10, 0, 1, 0, 3'b110);
    #1 begin cfg_done_i = 1'b0; prog_ni = 1'b0; end
    cyc(1);
    push("R9 program from startup", 2'b00, 0, 1, 0, 3'b110);
    #1 prog_ni = 1'b1;
    cyc(2);
    finish_run();
  end
endmodule